// File: doc/BRIEF.md
# Open-Row-Preferring Bank Request Scheduler

This block sits in front of a single DRAM bank and collects read and write requests from several threads in one shared queue of eight slots. Each slot holds the target row, the column, the issuing thread's ID, a caller-chosen tag and a write flag. The scheduler remembers which row the bank currently holds open. Whenever the bank is idle, it picks one pending request to serve.

Selection has two levels. Any request that targets the open row beats every request that targets another row. Within the chosen group, the request that has waited longest wins. An age matrix keeps the arrival order, so the oldest entry is always unambiguous. Only one request is in service at a time. A busy counter models the bank's cost: a short fixed time for an open-row hit, an activate phase added when no row is open, and a precharge phase added on top when a different row must first be closed. When service ends, a one-cycle completion pulse reports the served request and how it was classified, so that the order and timing can be checked from outside.

Top module: `rowhit_sched`

## Requirements
- R1: `req_ready` is high exactly when fewer than 8 requests are pending. A request is taken into the queue on a clock edge where `req_valid` and `req_ready` are both high, and it can be selected from the following cycle on.
- R2: When the bank is idle and at least one pending request targets the open row, the request selected is one that targets the open row.
- R3: Among the pending requests of equal open-row status, the one accepted earliest is selected.
- R4: A request that targets the open row completes with `done_kind` = 0 (hit). `done_valid` rises HIT_LAT (default 2) clock edges after the edge on which the request was selected.
- R5: After reset no row is open. The first request served completes with `done_kind` = 1 (activate only), HIT_LAT+ACT_LAT (default 5) edges after selection.
- R6: A request to a row other than the open one completes with `done_kind` = 2 (precharge and activate), HIT_LAT+ACT_LAT+PRE_LAT (default 8) edges after selection.
- R7: Once a request has been served, its row stays open, so a later request to the same row is classified as a hit.
- R8: `done_valid` is high for a single cycle. In that cycle `done_tid`, `done_tag`, `done_row`, `done_col` and `done_write` equal the fields of the served request, and `done_kind` is never 3.
- R9: Only one request is in service at a time. The next selection is made on the clock edge after the one that raises `done_valid`, and no entry leaves the queue while a request is in service.
- R10: While `rst_n` is low and after it is released, `done_valid` is 0 and `req_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | A request is offered |
| req_ready | output | 1 | A queue slot is free |
| req_write | input | 1 | 1 for a write, 0 for a read |
| req_row | input | ROW_W (8) | Target row |
| req_col | input | COL_W (6) | Target column |
| req_tid | input | TID_W (2) | ID of the issuing thread |
| req_tag | input | TAG_W (4) | Tag returned at completion |
| done_valid | output | 1 | One-cycle completion pulse |
| done_write | output | 1 | Write flag of the served request |
| done_row | output | ROW_W (8) | Row of the served request |
| done_col | output | COL_W (6) | Column of the served request |
| done_tid | output | TID_W (2) | Thread ID of the served request |
| done_tag | output | TAG_W (4) | Tag of the served request |
| done_kind | output | 2 | 0 hit, 1 activate only, 2 precharge and activate |

## Verification
The bench fills the queue while a long conflict service is running. Open-row requests are placed behind older conflicting ones, so a scheduler that used arrival order alone would return the tags in the wrong order, and one that failed to drop ready at eight entries would accept a ninth. Long streams over only four rows mix hits and conflicts with back-to-back arrivals. A wrong latency, a lost open row, or a tie broken by slot index instead of age then shows up as a completion in the wrong cycle, with the wrong kind or with the wrong tag. The first request after reset has to come out as activate only. A design that treated the empty row buffer as a match or as a conflict would report the wrong kind and complete too early or too late.

// File: rtl/rhs_pkg.sv
package rhs_pkg;

    // How a served request found the bank; the code values are visible on done_kind.
    typedef enum logic [1:0] {
        KIND_HIT      = 2'd0,
        KIND_OPEN     = 2'd1,
        KIND_CONFLICT = 2'd2
    } rhs_kind_e;

endpackage

// File: rtl/rhs_age_matrix.sv
// Relative age of queue slots: bit [i*DEPTH+j] set means slot i arrived before slot j.
module rhs_age_matrix #(
    parameter int DEPTH  = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     enq_go,
    input  logic [SLOT_W-1:0]        enq_slot,
    input  logic [DEPTH-1:0]         valid_now,
    output logic [DEPTH*DEPTH-1:0]   older
);

    logic [DEPTH*DEPTH-1:0] older_d, older_q;

    always_comb begin
        older_d = older_q;
        if (enq_go) begin
            for (int j = 0; j < DEPTH; j++) begin
                // The newcomer is older than nobody; every live entry is older than it.
                older_d[int'(enq_slot)*DEPTH + j] = 1'b0;
                older_d[j*DEPTH + int'(enq_slot)] = valid_now[j];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) older_q <= '0;
        else        older_q <= older_d;
    end

    assign older = older_q;

endmodule

// File: rtl/rhs_pick.sv
// Two-level choice: open-row hits first, then the oldest entry in the chosen group.
module rhs_pick
    import rhs_pkg::*;
#(
    parameter int DEPTH  = 8,
    parameter int ROW_W  = 8,
    localparam int SLOT_W = $clog2(DEPTH)
) (
    input  logic [DEPTH-1:0]              valid,
    input  logic [DEPTH-1:0][ROW_W-1:0]   rows,
    input  logic                          open_v,
    input  logic [ROW_W-1:0]              open_row,
    input  logic [DEPTH*DEPTH-1:0]        older,
    output logic                          go,
    output logic [SLOT_W-1:0]             slot,
    output logic                          any_hit,
    output rhs_kind_e                     kind
);

    logic [DEPTH-1:0] hitv;
    logic [DEPTH-1:0] cand;
    logic [DEPTH-1:0] blocked;
    logic [DEPTH-1:0] win;

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            hitv[i] = valid[i] && open_v && (rows[i] == open_row);
        end
        any_hit = |hitv;
        cand    = any_hit ? hitv : valid;
        for (int i = 0; i < DEPTH; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++) begin
                blocked[i] = blocked[i] | (cand[j] & older[j*DEPTH + i]);
            end
            win[i] = cand[i] & ~blocked[i];
        end
        slot = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (win[i]) slot = SLOT_W'(i);
        end
        go = |valid;
        if (any_hit)     kind = KIND_HIT;
        else if (open_v) kind = KIND_CONFLICT;
        else             kind = KIND_OPEN;
    end

endmodule

// File: rtl/rowhit_sched.sv
module rowhit_sched
    import rhs_pkg::*;
#(
    parameter int DEPTH   = 8,
    parameter int ROW_W   = 8,
    parameter int COL_W   = 6,
    parameter int TID_W   = 2,
    parameter int TAG_W   = 4,
    parameter int HIT_LAT = 2,
    parameter int ACT_LAT = 3,
    parameter int PRE_LAT = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_write,
    input  logic [ROW_W-1:0]  req_row,
    input  logic [COL_W-1:0]  req_col,
    input  logic [TID_W-1:0]  req_tid,
    input  logic [TAG_W-1:0]  req_tag,
    output logic              done_valid,
    output logic              done_write,
    output logic [ROW_W-1:0]  done_row,
    output logic [COL_W-1:0]  done_col,
    output logic [TID_W-1:0]  done_tid,
    output logic [TAG_W-1:0]  done_tag,
    output logic [1:0]        done_kind
);

    localparam int SLOT_W   = $clog2(DEPTH);
    localparam int MAX_LAT  = HIT_LAT + ACT_LAT + PRE_LAT;
    localparam int CNT_W    = $clog2(MAX_LAT + 1);

    typedef struct packed {
        logic [DEPTH-1:0]              valid;
        logic [DEPTH-1:0][ROW_W-1:0]   row;
        logic [DEPTH-1:0][COL_W-1:0]   col;
        logic [DEPTH-1:0][TID_W-1:0]   tid;
        logic [DEPTH-1:0][TAG_W-1:0]   tag;
        logic [DEPTH-1:0]              wr;
        logic                          open_v;
        logic [ROW_W-1:0]              open_row;
        logic                          busy;
        logic [CNT_W-1:0]              cnt;
        logic [ROW_W-1:0]              cur_row;
        logic [COL_W-1:0]              cur_col;
        logic [TID_W-1:0]              cur_tid;
        logic [TAG_W-1:0]              cur_tag;
        logic                          cur_wr;
        rhs_kind_e                     cur_kind;
        logic                          done;
    } state_t;

    state_t st_d, st_q;

    logic [DEPTH*DEPTH-1:0] older;
    logic                   pick_go;
    logic [SLOT_W-1:0]      pick_slot;
    logic                   any_hit;
    rhs_kind_e              pick_kind;
    logic [SLOT_W-1:0]      enq_slot;
    logic                   enq_go;
    logic                   issue_go;
    logic                   busy_q;

    // Lowest free slot takes the next arrival.
    always_comb begin
        enq_slot = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!st_q.valid[i]) enq_slot = SLOT_W'(i);
        end
    end

    assign req_ready = ~&st_q.valid;
    assign enq_go    = req_valid && req_ready;
    assign issue_go  = !st_q.busy && pick_go;
    assign busy_q    = st_q.busy;

    rhs_age_matrix #(.DEPTH(DEPTH)) u_age (
        .clk       (clk),
        .rst_n     (rst_n),
        .enq_go    (enq_go),
        .enq_slot  (enq_slot),
        .valid_now (st_q.valid),
        .older     (older)
    );

    rhs_pick #(.DEPTH(DEPTH), .ROW_W(ROW_W)) u_pick (
        .valid    (st_q.valid),
        .rows     (st_q.row),
        .open_v   (st_q.open_v),
        .open_row (st_q.open_row),
        .older    (older),
        .go       (pick_go),
        .slot     (pick_slot),
        .any_hit  (any_hit),
        .kind     (pick_kind)
    );

    always_comb begin
        st_d      = st_q;
        st_d.done = 1'b0;
        if (st_q.busy) begin
            if (st_q.cnt == CNT_W'(1)) begin
                st_d.busy = 1'b0;
                st_d.done = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt - CNT_W'(1);
            end
            // Activate phase ends here: the new row is now open in the row buffer.
            if (st_q.cur_kind != KIND_HIT && st_q.cnt == CNT_W'(HIT_LAT + 1)) begin
                st_d.open_v   = 1'b1;
                st_d.open_row = st_q.cur_row;
            end
        end else if (pick_go) begin
            st_d.valid[pick_slot] = 1'b0;
            st_d.busy     = 1'b1;
            st_d.cur_row  = st_q.row[pick_slot];
            st_d.cur_col  = st_q.col[pick_slot];
            st_d.cur_tid  = st_q.tid[pick_slot];
            st_d.cur_tag  = st_q.tag[pick_slot];
            st_d.cur_wr   = st_q.wr[pick_slot];
            st_d.cur_kind = pick_kind;
            unique case (pick_kind)
                KIND_HIT:  st_d.cnt = CNT_W'(HIT_LAT);
                KIND_OPEN: st_d.cnt = CNT_W'(HIT_LAT + ACT_LAT);
                default: begin
                    st_d.cnt    = CNT_W'(MAX_LAT);
                    st_d.open_v = 1'b0;
                end
            endcase
        end
        if (enq_go) begin
            st_d.valid[enq_slot] = 1'b1;
            st_d.row[enq_slot]   = req_row;
            st_d.col[enq_slot]   = req_col;
            st_d.tid[enq_slot]   = req_tid;
            st_d.tag[enq_slot]   = req_tag;
            st_d.wr[enq_slot]    = req_write;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign done_valid = st_q.done;
    assign done_write = st_q.cur_wr;
    assign done_row   = st_q.cur_row;
    assign done_col   = st_q.cur_col;
    assign done_tid   = st_q.cur_tid;
    assign done_tag   = st_q.cur_tag;
    assign done_kind  = st_q.cur_kind;

endmodule

// File: rtl/rhs_checker.sv
module rhs_checker
    import rhs_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic             done_valid,
    input logic [1:0]       done_kind,
    input logic [DEPTH-1:0] valid_vec,
    input logic             busy,
    input logic             issue_go,
    input logic             any_hit,
    input rhs_kind_e        issue_kind
);

    logic seen_done_q;

    always_ff @(posedge clk) begin
        if (!rst_n)          seen_done_q <= 1'b0;
        else if (done_valid) seen_done_q <= 1'b1;
    end

    // Without a handshake the queue can only shrink.
    assert_no_overflow_R1: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> $countones(valid_vec) <= $past($countones(valid_vec)));

    assert_hit_first_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (issue_go && any_hit) |-> issue_kind == KIND_HIT);

    assert_first_open_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (done_valid && !seen_done_q) |-> done_kind == 2'd1);

    assert_single_pulse_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |=> !done_valid);

    assert_kind_legal_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done_valid |-> done_kind != 2'd3);

    assert_hold_while_busy_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && !(req_valid && req_ready)) |=> valid_vec == $past(valid_vec));

endmodule

bind rowhit_sched rhs_checker #(.DEPTH(DEPTH)) u_rhs_checker (
    .clk        (clk),
    .rst_n      (rst_n),
    .req_valid  (req_valid),
    .req_ready  (req_ready),
    .done_valid (done_valid),
    .done_kind  (done_kind),
    .valid_vec  (st_q.valid),
    .busy       (busy_q),
    .issue_go   (issue_go),
    .any_hit    (any_hit),
    .issue_kind (pick_kind)
);

// File: tb/test_rowhit_sched.sv
`timescale 1ns/1ps
module test_rowhit_sched;

    localparam int DEPTH = 8;
    localparam int ROW_W = 8;
    localparam int COL_W = 6;
    localparam int TID_W = 2;
    localparam int TAG_W = 4;
    localparam int HIT   = 2;
    localparam int ACT   = 3;
    localparam int PRE   = 3;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             req_valid = 1'b0;
    logic             req_ready;
    logic             req_write = 1'b0;
    logic [ROW_W-1:0] req_row = '0;
    logic [COL_W-1:0] req_col = '0;
    logic [TID_W-1:0] req_tid = '0;
    logic [TAG_W-1:0] req_tag = '0;
    logic             done_valid;
    logic             done_write;
    logic [ROW_W-1:0] done_row;
    logic [COL_W-1:0] done_col;
    logic [TID_W-1:0] done_tid;
    logic [TAG_W-1:0] done_tag;
    logic [1:0]       done_kind;

    always #2 clk = ~clk;

    rowhit_sched i_rowhit_sched (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_row(req_row), .req_col(req_col),
        .req_tid(req_tid), .req_tag(req_tag), .done_valid(done_valid),
        .done_write(done_write), .done_row(done_row), .done_col(done_col),
        .done_tid(done_tid), .done_tag(done_tag), .done_kind(done_kind)
    );

    typedef struct {
        int row;
        int col;
        int tid;
        int tag;
        int wr;
    } mreq_t;

    mreq_t mq[$];
    mreq_t m_cur;
    int    m_kind;
    bit    m_busy;
    int    m_cnt;
    int    m_open;
    bit    m_done;
    int    n_chk;
    int    n_bad;
    int    cycles;
    bit    ended;

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic report();
        ended = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    endtask

    // Behavioural reference: arrival-ordered queue, open row, service countdown.
    always @(posedge clk) begin
        if (!rst_n) begin
            mq.delete();
            m_busy = 1'b0;
            m_cnt  = 0;
            m_open = -1;
            m_done = 1'b0;
        end else begin : model_step
            bit acc;
            int idx;
            acc    = req_valid && (mq.size() < DEPTH);
            m_done = 1'b0;
            if (m_busy) begin
                if (m_cnt == 1) begin
                    m_done = 1'b1;
                    m_busy = 1'b0;
                end else begin
                    m_cnt--;
                end
            end else if (mq.size() > 0) begin
                idx = 0;
                for (int i = mq.size() - 1; i >= 0; i--) begin
                    if (mq[i].row == m_open) idx = i;
                end
                m_cur = mq[idx];
                if (m_cur.row == m_open) begin
                    m_kind = 0; m_cnt = HIT;
                end else if (m_open < 0) begin
                    m_kind = 1; m_cnt = HIT + ACT;
                end else begin
                    m_kind = 2; m_cnt = HIT + ACT + PRE;
                end
                mq.delete(idx);
                m_busy = 1'b1;
                m_open = m_cur.row;
            end
            if (acc) begin
                mq.push_back('{int'(req_row), int'(req_col), int'(req_tid),
                               int'(req_tag), int'(req_write)});
            end
        end
    end

    // Compare every cycle, away from the active edge.
    always @(negedge clk) begin
        if (rst_n && !ended) begin
            check(req_ready == (mq.size() < DEPTH), "R1 ready", req_ready, mq.size() < DEPTH);
            check(done_valid == m_done, "R4 R5 R6 R9 completion timing", done_valid, m_done);
            if (m_done && done_valid) begin
                if (m_kind == 0)      check(done_kind == 0, "R4 R7 hit kind", done_kind, 0);
                else if (m_kind == 1) check(done_kind == 1, "R5 first-open kind", done_kind, 1);
                else                  check(done_kind == 2, "R6 conflict kind", done_kind, 2);
                check(done_tag == m_cur.tag, "R2 R3 service order tag", done_tag, m_cur.tag);
                check(done_row == m_cur.row, "R8 row", done_row, m_cur.row);
                check(done_col == m_cur.col, "R8 col", done_col, m_cur.col);
                check(done_tid == m_cur.tid, "R8 tid", done_tid, m_cur.tid);
                check(done_write == m_cur.wr, "R8 write", done_write, m_cur.wr);
            end
        end
    end

    always @(posedge clk) begin
        cycles++;
        if (cycles >= 100000 && !ended) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual %0d expected %0d", cycles, 0);
            report();
        end
    end

    // Called just after a falling edge; returns just after the falling edge that follows acceptance.
    task automatic push(int row, int col, int tid, int tag, int wr);
        req_valid = 1'b1;
        req_row   = ROW_W'(row);
        req_col   = COL_W'(col);
        req_tid   = TID_W'(tid);
        req_tag   = TAG_W'(tag);
        req_write = wr[0];
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    task automatic idle(int n);
        req_valid = 1'b0;
        repeat (n) @(negedge clk);
    endtask

    task automatic drain();
        req_valid = 1'b0;
        while (mq.size() > 0 || m_busy) @(negedge clk);
        repeat (3) @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R10: reset values while held and after release.
        check(done_valid == 1'b0, "R10 done in reset", done_valid, 0);
        check(req_ready == 1'b1, "R10 ready in reset", req_ready, 1);
        rst_n = 1'b1;
        @(negedge clk);
        check(done_valid == 1'b0, "R10 done after reset", done_valid, 0);
        check(req_ready == 1'b1, "R10 ready after reset", req_ready, 1);

        // R5: first access after reset opens a row without precharge.
        push(5, 1, 0, 1, 0);
        drain();
        // R7: the same row stays open, so this one is a hit.
        push(5, 2, 1, 2, 1);
        drain();

        // R1 R2 R3: flood the queue behind a long conflict service.
        push(9, 3, 2, 3, 0);
        push(7, 4, 0, 4, 1);
        push(9, 5, 1, 5, 0);
        push(3, 6, 2, 6, 1);
        push(9, 7, 3, 7, 0);
        push(7, 8, 0, 8, 0);
        push(1, 9, 1, 9, 1);
        push(9, 10, 2, 10, 0);
        push(4, 11, 3, 11, 1);
        push(9, 12, 0, 12, 0);
        push(2, 13, 1, 13, 1);
        drain();

        // Mixed stream over a few rows: hits, conflicts and back-to-back arrivals.
        for (int k = 0; k < 400; k++) begin
            if ($urandom_range(1, 0) == 1)
                push(int'($urandom_range(3, 0)), int'($urandom_range(63, 0)),
                     int'($urandom_range(3, 0)), k & 15, int'($urandom_range(1, 0)));
            else
                idle(1);
        end
        drain();

        // Back-to-back conflicts on distinct rows: pure age order (R3, R6).
        push(20, 1, 0, 1, 0);
        push(21, 2, 1, 2, 0);
        push(22, 3, 2, 3, 1);
        push(23, 4, 3, 4, 1);
        drain();

        report();
    end

endmodule